// File: doc/BRIEF.md
# Configuration Sequencer for a Programmable Logic Device

This block is the control sequencer that takes a programmable logic device from power-up, or from a reload request, into user operation. It runs three ordered phases. First it clears configuration memory. Next it accepts configuration frames. Last it runs a short start-up sequence that hands the device over to the user design. Data shifting, frame addressing and integrity checking sit outside the block. It only sees a strobe for each frame written, plus a flag that marks the final frame.

During memory clearing the block holds the init line low. That line is open-drain and shared, so other parties can also hold it low. While it stays low, the block waits and does not start loading. After the final frame the block pulses a global set/reset once. It then raises done, releases the global output tristate one clock later, and releases the global write enable one clock after that. An optional mode holds both releases until a done line shared by several devices reads high. A low level on the program request aborts everything and restarts memory clearing.

Top module: `cfg_sequencer`

## Requirements
- R1: While `rst` is high, every clock leaves `phase` = 0 (idle), `done` = 0, `gsr` = 0, `gts` = 1, `gwe` = 0 and the init line driven low (`init_n` = 0).
- R2: Configuration starts by itself. One clock after reset is released, `phase` = 1 (clear) and `init_n` stays low.
- R3: The clear phase lasts exactly `CLR_CYCLES` clocks, counted from its entry or from the release of the program request. After that, `phase` = 2 (wait-init) and the block stops driving init low.
- R4: `init_n` is the wired-AND of the block's own drive and `init_ext_n`. In wait-init the block stays put while `init_n` is low. It moves to `phase` = 3 (load) on the clock where `init_n` is sampled high.
- R5: In load, a clock with `frame_wr` = 1 and `frame_last` = 1 moves to `phase` = 4 (start-up) and raises `gsr` for exactly one clock. A `frame_wr` without `frame_last` keeps the block in load. Frame strobes in any other phase have no effect.
- R6: `done` rises on the clock after the `gsr` pulse.
- R7: `gts` falls one clock after `done` rises. `gwe` rises one clock after `gts` falls, and at that same edge `phase` becomes 5 (user).
- R8: With `bus_gate_en` = 1, `gts` stays high while `done_bus` is sampled low with `done` high. It falls on the first clock where `done_bus` is sampled high. `gwe` then follows one clock later.
- R9: A clock with `prog_n` = 0 in any phase gives, on the next clock, `phase` = 1, `done` = 0, `gsr` = 0, `gts` = 1 and `gwe` = 0. The block holds this state while `prog_n` stays low.
- R10: `gwe` is high only in the user phase, and `gts` is low only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| prog_n | input | 1 | Program request, active low; aborts and restarts configuration |
| init_ext_n | input | 1 | External contribution to the open-drain init line (0 = held low outside) |
| frame_wr | input | 1 | One configuration frame has been written |
| frame_last | input | 1 | Qualifies `frame_wr` as the final frame |
| done_bus | input | 1 | Shared done line of all chained devices |
| bus_gate_en | input | 1 | 1 = hold the tristate and write-enable releases until `done_bus` is high |
| init_n | output | 1 | Resolved level of the init line |
| done | output | 1 | Configuration complete |
| gsr | output | 1 | One-clock global set/reset pulse |
| gts | output | 1 | Global output tristate, 1 = outputs held off |
| gwe | output | 1 | Global write enable, 1 = storage elements may change |
| phase | output | 3 | Phase code: 0 idle, 1 clear, 2 wait-init, 3 load, 4 start-up, 5 user |

## Verification
The assertions assume that `prog_n`, `init_ext_n`, `frame_wr`, `frame_last`, `done_bus` and `bus_gate_en` are synchronous to the configuration clock and stable around each rising edge. They also assume that `frame_last` has meaning only together with `frame_wr`. The bench changes every input one time unit after a rising edge and samples outputs at that same point. It never presents a final frame outside the intended phase except to show that the frame is ignored. It changes `bus_gate_en` only while the block is clearing.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_CLEAR     = 3'd1,
        PH_WAIT_INIT = 3'd2,
        PH_LOAD      = 3'd3,
        PH_START     = 3'd4,
        PH_USER      = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        SU_OFF,
        SU_PULSE,
        SU_DONE,
        SU_OUT_ON,
        SU_RUN
    } su_step_e;

    typedef struct packed {
        logic gsr;
        logic done;
        logic gts;
        logic gwe;
    } glob_ctl_t;

    localparam glob_ctl_t GLOB_SAFE = '{gsr: 1'b0, done: 1'b0, gts: 1'b1, gwe: 1'b0};

    function automatic logic holds_init_low(phase_e p);
        return (p == PH_IDLE) || (p == PH_CLEAR);
    endfunction

endpackage

// File: rtl/cfg_seq_clear_timer.sv
module cfg_seq_clear_timer #(
    parameter int CLR_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CLR_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CLEAR_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/cfg_seq_startup.sv
module cfg_seq_startup
    import cfg_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      abort,
    input  logic      go,
    input  logic      bus_gate_en,
    input  logic      done_bus,
    output glob_ctl_t ctl,
    output logic      finishing
);
    su_step_e step_q;

    assign finishing = (step_q == SU_OUT_ON) && !abort;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            step_q <= SU_OFF;
            ctl    <= GLOB_SAFE;
        end else begin
            case (step_q)
                SU_OFF: begin
                    if (go) begin
                        ctl.gsr <= 1'b1;
                        step_q  <= SU_PULSE;
                    end
                end
                SU_PULSE: begin
                    ctl.gsr  <= 1'b0;
                    ctl.done <= 1'b1;
                    step_q   <= SU_DONE;
                end
                SU_DONE: begin
                    if (!bus_gate_en || done_bus) begin
                        ctl.gts <= 1'b0;
                        step_q  <= SU_OUT_ON;
                    end
                end
                SU_OUT_ON: begin
                    ctl.gwe <= 1'b1;
                    step_q  <= SU_RUN;
                end
                SU_RUN: begin
                    step_q <= SU_RUN;
                end
                default: begin
                    step_q <= SU_OFF;
                    ctl    <= GLOB_SAFE;
                end
            endcase
        end
    end

    AST_GSR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.gsr |=> !ctl.gsr); // R5

    AST_DONE_AFTER_GSR: assert property (@(posedge clk) disable iff (rst)
        (ctl.gsr && !abort) |=> ctl.done); // R6

    AST_GWE_AFTER_GTS: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.gwe) |-> (!ctl.gts && $past(!ctl.gts))); // R7

    AST_GTS_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_gate_en && !done_bus && ctl.gts) |=> ctl.gts); // R8

    AST_GTS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        !ctl.gts |-> ctl.done); // R10

endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int CLR_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_n,
    input  logic       init_ext_n,
    input  logic       frame_wr,
    input  logic       frame_last,
    input  logic       done_bus,
    input  logic       bus_gate_en,
    output logic       init_n,
    output logic       done,
    output logic       gsr,
    output logic       gts,
    output logic       gwe,
    output logic [2:0] phase
);
    phase_e    phase_q;
    logic      clr_run;
    logic      clr_expired;
    logic      su_go;
    logic      su_finishing;
    glob_ctl_t ctl;

    assign clr_run = (phase_q == PH_CLEAR) && prog_n;
    assign su_go   = (phase_q == PH_LOAD) && frame_wr && frame_last;
    assign init_n  = !holds_init_low(phase_q) && init_ext_n;

    cfg_seq_clear_timer #(
        .CLR_CYCLES(CLR_CYCLES)
    ) i_clear_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (clr_run),
        .expired(clr_expired)
    );

    cfg_seq_startup i_startup (
        .clk        (clk),
        .rst        (rst),
        .abort      (!prog_n),
        .go         (su_go),
        .bus_gate_en(bus_gate_en),
        .done_bus   (done_bus),
        .ctl        (ctl),
        .finishing  (su_finishing)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (!prog_n) begin
            phase_q <= PH_CLEAR;
        end else begin
            case (phase_q)
                PH_IDLE:      phase_q <= PH_CLEAR;
                PH_CLEAR:     if (clr_expired) phase_q <= PH_WAIT_INIT;
                PH_WAIT_INIT: if (init_n) phase_q <= PH_LOAD;
                PH_LOAD:      if (su_go) phase_q <= PH_START;
                PH_START:     if (su_finishing) phase_q <= PH_USER;
                PH_USER:      phase_q <= PH_USER;
                default:      phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done  = ctl.done;
    assign gsr   = ctl.gsr;
    assign gts   = ctl.gts;
    assign gwe   = ctl.gwe;
    assign phase = phase_q;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (phase_q == PH_IDLE && !done && !gsr && gts && !gwe && !init_n)); // R1

    AST_AUTO_START: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && prog_n) |=> (phase_q == PH_CLEAR)); // R2

    AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CLEAR && prog_n && !clr_expired) |=> (phase_q == PH_CLEAR)); // R3

    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT_INIT && !init_n && prog_n) |=> (phase_q == PH_WAIT_INIT)); // R4

    AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (rst)
        !prog_n |=> (phase_q == PH_CLEAR && !done && !gsr && gts && !gwe)); // R9

    AST_GWE_USER_ONLY: assert property (@(posedge clk) disable iff (rst)
        gwe |-> (phase_q == PH_USER)); // R10

endmodule

// File: tb/test_cfg_sequencer.sv
module test_cfg_sequencer;

    localparam int NCLR = 4;
    localparam int NVEC = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_n = 1'b1;
    logic init_ext_n = 1'b1;
    logic frame_wr = 1'b0;
    logic frame_last = 1'b0;
    logic done_bus = 1'b0;
    logic bus_gate_en = 1'b0;
    logic init_n, done, gsr, gts, gwe;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cfg_sequencer #(.CLR_CYCLES(NCLR)) i_cfg_sequencer (
        .clk(clk), .rst(rst), .prog_n(prog_n), .init_ext_n(init_ext_n),
        .frame_wr(frame_wr), .frame_last(frame_last), .done_bus(done_bus),
        .bus_gate_en(bus_gate_en), .init_n(init_n), .done(done), .gsr(gsr),
        .gts(gts), .gwe(gwe), .phase(phase)
    );

    // inputs {prog_n, init_ext_n, frame_wr, frame_last, done_bus}
    // expected {phase[2:0], done, gts, gwe, gsr, init_n}
    localparam logic [12:0] VEC [NVEC] = '{
        13'b1_1_0_0_0_001_0_1_0_0_0,
        13'b1_1_0_0_0_001_0_1_0_0_0,
        13'b1_1_0_0_0_001_0_1_0_0_0,
        13'b1_1_0_0_0_001_0_1_0_0_0,
        13'b1_1_0_0_0_010_0_1_0_0_1,
        13'b1_0_1_1_0_010_0_1_0_0_0,
        13'b1_0_0_0_0_010_0_1_0_0_0,
        13'b1_1_0_0_0_011_0_1_0_0_1,
        13'b1_1_1_0_0_011_0_1_0_0_1,
        13'b1_1_0_0_0_011_0_1_0_0_1,
        13'b1_1_1_1_0_100_0_1_0_1_1,
        13'b1_1_0_0_0_100_1_1_0_0_1,
        13'b1_1_0_0_0_100_1_0_0_0_1,
        13'b1_1_0_0_0_101_1_0_1_0_1,
        13'b1_1_1_1_0_101_1_0_1_0_1
    };

    function automatic string row_req(int i);
        if (i == 0) return "R2";
        if (i <= 4) return "R3";
        if (i <= 7) return "R4";
        if (i <= 10) return "R5";
        if (i == 11) return "R6";
        return "R7";
    endfunction

    function automatic logic [7:0] observe();
        return {phase, done, gts, gwe, gsr, init_n};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [7:0] exp);
        logic [7:0] act;
        act = observe();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b (phase,done,gts,gwe,gsr,init_n)", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        step(); step(); step();
        check("R1", 8'b000_0_1_0_0_0);
        rst = 1'b0;

        // table of vectors: R2..R7 main flow, incl. ignored frames (R5)
        for (int i = 0; i < NVEC; i++) begin
            {prog_n, init_ext_n, frame_wr, frame_last, done_bus} = VEC[i][12:8];
            step();
            check(row_req(i), VEC[i][7:0]);
        end
        frame_wr = 1'b0;
        frame_last = 1'b0;

        // R9: abort from user phase, held while request low
        prog_n = 1'b0;
        step();
        check("R9", 8'b001_0_1_0_0_0);
        step();
        check("R9", 8'b001_0_1_0_0_0);
        prog_n = 1'b1;
        step(); step(); step();
        check("R3", 8'b001_0_1_0_0_0);
        step();
        check("R3", 8'b010_0_1_0_0_1);
        step();
        check("R4", 8'b011_0_1_0_0_1);

        // R9: abort during the set/reset pulse
        frame_wr = 1'b1;
        frame_last = 1'b1;
        step();
        check("R5", 8'b100_0_1_0_1_1);
        frame_wr = 1'b0;
        frame_last = 1'b0;
        prog_n = 1'b0;
        step();
        check("R9", 8'b001_0_1_0_0_0);
        prog_n = 1'b1;

        // R8: releases gated on the shared done line
        bus_gate_en = 1'b1;
        done_bus = 1'b0;
        repeat (NCLR + 1) step();
        check("R4", 8'b011_0_1_0_0_1);
        frame_wr = 1'b1;
        frame_last = 1'b1;
        step();
        check("R5", 8'b100_0_1_0_1_1);
        frame_wr = 1'b0;
        frame_last = 1'b0;
        step();
        check("R6", 8'b100_1_1_0_0_1);
        step();
        check("R8", 8'b100_1_1_0_0_1);
        step();
        check("R10", 8'b100_1_1_0_0_1);
        done_bus = 1'b1;
        step();
        check("R8", 8'b100_1_0_0_0_1);
        step();
        check("R7", 8'b101_1_0_1_0_1);

        // R1: reset from user phase, then R2 auto start
        rst = 1'b1;
        step();
        check("R1", 8'b000_0_1_0_0_0);
        rst = 1'b0;
        step();
        check("R2", 8'b001_0_1_0_0_0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule